// File: doc/BRIEF.md
# Grid-Locked Periodic Pulse Generator

This block drives one digital output whose edges are pinned to a free-running time counter. Software supplies a period, a phase offset and, optionally, an on-time. Every cycle of the waveform starts with a rising edge at a counter value of the form k*period + phase, for any integer k. The output then stays high for on-time counts and is low for the rest of the period. There is no polarity option, and the high level may fill any share of the period from nothing up to all of it.

The configuration is captured at the clock edge where the enable is first seen high. The block checks it, then spends a fixed setup interval of TW clocks finding where the counter lies inside the period grid. This uses a serial remainder unit, so no wide divider is needed. The output becomes active only at a grid point, so a new configuration never produces a truncated pulse. The counter is an input and is assumed to advance by one each clock. The output is registered, so it shows, one clock later, the level that belongs to the counter value sampled at that edge.

Top module: `grid_pulse_gen`

## Requirements
- R1: While reset is active, and at the first sample after reset, pulse_out and cfg_error are both 0.
- R2: With a counter value t sampled at an edge while the block is running, pulse_out goes high after that edge exactly when (t - phase) mod period equals 0. This is a grid point, and the rise happens only there.
- R3: After an edge that sampled counter value t, pulse_out is high exactly when (t - phase) mod period < on-time. An on-time of 0 gives no high level at all.
- R4: An on-time above half the period is honoured. For example, period 10, phase 2 and on-time 7 give a high level for t in [10k+2, 10k+9).
- R5: When cfg_on_valid is 0, cfg_on_time is ignored and the on-time used is floor(period/2).
- R6: With cfg_on_valid at 1 and cfg_on_time greater than cfg_period, the configuration is rejected. cfg_error is 1 from the edge after capture, and pulse_out stays 0. With cfg_on_valid at 0, the same on-time value is not an error.
- R7: A period of 0, or a phase greater than or equal to the period, is rejected in the same way: cfg_error goes to 1 and pulse_out stays 0.
- R8: If enable is first sampled high with counter value T0, pulse_out stays 0 until the first grid point G at or after T0 + TW, where TW is the counter width. From G on, R3 applies.
- R9: An on-time equal to the period keeps pulse_out high without a break from the first grid point on.
- R10: Changes on cfg_period, cfg_phase, cfg_on_time and cfg_on_valid while enabled have no effect on pulse_out.
- R11: After an edge that samples cfg_enable at 0, pulse_out and cfg_error are 0. A later enable recaptures the configuration and starts again per R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_cnt | input | TW | Free-running time counter, one count per clock |
| cfg_enable | input | 1 | Run request; the rising sample captures the configuration |
| cfg_period | input | TW | Period in counter units |
| cfg_phase | input | TW | Offset of the rising edge within the period |
| cfg_on_time | input | TW | High duration in counter units |
| cfg_on_valid | input | 1 | 1 selects cfg_on_time, 0 selects half the period |
| pulse_out | output | 1 | Generated waveform |
| cfg_error | output | 1 | Captured configuration was rejected |

## Verification
The bench targets duty cycles above one half, where a design that treated the on-time as a low-time or clipped it to half the period would show a wrong falling edge. It also covers an on-time equal to the period, where an off-by-one comparison would let a one-count low glitch through, and an on-time of zero, which must never produce a pulse. Start-up is checked against the exact first grid point, so remainder or offset arithmetic that is off by one count would show as a pulse that is shifted, early or a runt. Each rejection rule is exercised, including an oversized on-time with the flag clear, which must not be flagged. Configuration inputs are changed mid-run to catch a design that does not hold the captured values.

// File: rtl/pgen_pkg.sv
// Shared types for the grid-locked pulse generator.
// Assumes nothing beyond a single clock domain.
package pgen_pkg;
    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_SETUP = 2'd1,
        PG_RUN   = 2'd2,
        PG_FAULT = 2'd3
    } pg_state_e;
endpackage

// File: rtl/pgen_cfg_check.sv
// Configuration check: flags an unusable period, phase or on-time and
// selects the effective on-time (half the period when none is given).
// Purely combinational; the caller captures the results.
module pgen_cfg_check #(
    parameter int TW = 64
) (
    input  logic [TW-1:0] period,
    input  logic [TW-1:0] phase,
    input  logic [TW-1:0] on_time,
    input  logic          on_valid,
    output logic          bad,
    output logic [TW-1:0] on_eff
);
    // Rejection rules and default duty selection.
    always_comb begin
        bad    = (period == '0) || (phase >= period) ||
                 (on_valid && (on_time > period));
        on_eff = on_valid ? on_time : (period >> 1);
    end
endmodule

// File: rtl/pgen_rem_div.sv
// Serial remainder unit: computes dividend mod divisor, one bit per clock.
// 'start' loads the operands. The last step is flagged by 'last', with
// the final remainder on rem_next in that same cycle. Assumes divisor != 0.
module pgen_rem_div #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] dividend,
    input  logic [TW-1:0] divisor,
    output logic          last,
    output logic [TW-1:0] rem_next
);
    localparam int CW = $clog2(TW + 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [TW-1:0] dq;
    logic [TW-1:0] dv;
    logic [TW-1:0] rem;
    logic [TW:0]   trial;
    logic [TW:0]   diff;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        trial    = {rem, dq[TW-1]};
        diff     = trial - {1'b0, dv};
        rem_next = (trial >= {1'b0, dv}) ? diff[TW-1:0] : trial[TW-1:0];
        last     = busy && (cnt == CW'(1));
    end

    // Operand capture and step sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            dq   <= '0;
            dv   <= '0;
            rem  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(TW);
            dq   <= dividend;
            dv   <= divisor;
            rem  <= '0;
        end else if (busy) begin
            rem  <= rem_next;
            dq   <= {dq[TW-2:0], 1'b0};
            cnt  <= cnt - CW'(1);
            if (cnt == CW'(1)) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/pgen_grid_pos.sv
// Grid position: (rem + wofs - phase) mod period. The inputs rem, wofs and
// phase must each be below period. Combinational, with one guard bit.
module pgen_grid_pos #(
    parameter int TW = 64
) (
    input  logic [TW-1:0] rem,
    input  logic [TW-1:0] wofs,
    input  logic [TW-1:0] phase,
    input  logic [TW-1:0] period,
    output logic [TW-1:0] pos
);
    logic [TW:0] s;
    logic [TW:0] s2;
    logic [TW:0] d;

    // Two conditional corrections bring the sum back into [0, period).
    always_comb begin
        s   = {1'b0, rem} + {1'b0, wofs};
        s2  = (s >= {1'b0, period}) ? (s - {1'b0, period}) : s;
        d   = (s2 >= {1'b0, phase}) ? (s2 - {1'b0, phase})
                                    : (s2 + {1'b0, period} - {1'b0, phase});
        pos = d[TW-1:0];
    end
endmodule

// File: rtl/grid_pulse_gen.sv
// Grid-locked periodic pulse generator. It captures the configuration on
// enable, finds the counter's place in the period grid over TW clocks,
// and starts at the next grid point. Output is high while
// (t - phase) mod period < on-time.
// Assumes time_cnt advances by exactly one per clock.
module grid_pulse_gen #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_cnt,
    input  logic          cfg_enable,
    input  logic [TW-1:0] cfg_period,
    input  logic [TW-1:0] cfg_phase,
    input  logic [TW-1:0] cfg_on_time,
    input  logic          cfg_on_valid,
    output logic          pulse_out,
    output logic          cfg_error
);
    import pgen_pkg::*;

    localparam logic [TW:0] ONE = (TW + 1)'(1);

    pg_state_e     state;
    logic [TW-1:0] per_r, ph_r, on_r;
    logic [TW-1:0] wofs, pos;
    logic          started;

    logic          bad;
    logic [TW-1:0] on_eff;
    logic          div_start, div_last;
    logic [TW-1:0] div_rem;
    logic [TW-1:0] pos_calc, w_next, pos_inc, pos_n;
    logic [TW:0]   w_sum, p_sum;
    logic          start_n, hi_n;

    pgen_cfg_check #(.TW(TW)) u_check (
        .period   (cfg_period),
        .phase    (cfg_phase),
        .on_time  (cfg_on_time),
        .on_valid (cfg_on_valid),
        .bad      (bad),
        .on_eff   (on_eff)
    );

    assign div_start = (state == PG_IDLE) && cfg_enable && !bad;

    pgen_rem_div #(.TW(TW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (time_cnt),
        .divisor  (cfg_period),
        .last     (div_last),
        .rem_next (div_rem)
    );

    pgen_grid_pos #(.TW(TW)) u_pos (
        .rem    (div_rem),
        .wofs   (w_next),
        .phase  (ph_r),
        .period (per_r),
        .pos    (pos_calc)
    );

    // Modulo-period increments of the setup offset and the run position.
    always_comb begin
        w_sum   = {1'b0, wofs} + ONE;
        p_sum   = {1'b0, pos} + ONE;
        w_next  = (w_sum == {1'b0, per_r}) ? '0 : w_sum[TW-1:0];
        pos_inc = (p_sum == {1'b0, per_r}) ? '0 : p_sum[TW-1:0];
        pos_n   = (state == PG_SETUP) ? pos_calc : pos_inc;
        start_n = started || (pos_n == '0);
        hi_n    = start_n && (pos_n < on_r);
    end

    // Control sequence: capture, setup, run, or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PG_IDLE;
            per_r     <= '0;
            ph_r      <= '0;
            on_r      <= '0;
            wofs      <= '0;
            pos       <= '0;
            started   <= 1'b0;
            pulse_out <= 1'b0;
            cfg_error <= 1'b0;
        end else if (!cfg_enable) begin
            state     <= PG_IDLE;
            started   <= 1'b0;
            pulse_out <= 1'b0;
            cfg_error <= 1'b0;
        end else begin
            case (state)
                PG_IDLE: begin
                    per_r <= cfg_period;
                    ph_r  <= cfg_phase;
                    on_r  <= on_eff;
                    wofs  <= '0;
                    if (bad) begin
                        state     <= PG_FAULT;
                        cfg_error <= 1'b1;
                    end else begin
                        state <= PG_SETUP;
                    end
                end
                PG_SETUP: begin
                    wofs <= w_next;
                    if (div_last) begin
                        pos       <= pos_n;
                        started   <= start_n;
                        pulse_out <= hi_n;
                        state     <= PG_RUN;
                    end
                end
                PG_RUN: begin
                    pos       <= pos_n;
                    started   <= start_n;
                    pulse_out <= hi_n;
                end
                default: begin
                    pulse_out <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/grid_pulse_gen_chk.sv
// Checker for grid_pulse_gen: watches the ports and the captured state.
// It is attached to every instance through the bind below.
module grid_pulse_gen_chk #(
    parameter int TW = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_enable,
    input logic                pulse_out,
    input logic                cfg_error,
    input pgen_pkg::pg_state_e state,
    input logic [TW-1:0]       pos,
    input logic [TW-1:0]       on_r,
    input logic [TW-1:0]       per_r
);
    import pgen_pkg::*;

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> !pulse_out);

    // R11
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!pulse_out && !cfg_error));

    // R2
    rise_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> (pos == '0));

    // R3
    fall_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_out) && state == PG_RUN) |-> (pos == on_r));

    // R8
    run_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> (state == PG_RUN));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PG_RUN && $past(state) == PG_RUN) |-> ($stable(per_r) && $stable(on_r)));
endmodule

bind grid_pulse_gen grid_pulse_gen_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .pulse_out  (pulse_out),
    .cfg_error  (cfg_error),
    .state      (state),
    .pos        (pos),
    .on_r       (on_r),
    .per_r      (per_r)
);

// File: tb/tb_grid_pulse_gen.sv
// Bench for grid_pulse_gen: a vector table of waveform setups walked by one
// loop, then directed tests for reset, rejection, held config and disable.
module tb_grid_pulse_gen;
    localparam int  TW     = 64;
    localparam time CLK_PD = 10ns;
    localparam int  NV     = 6;

    localparam logic [63:0] VP  [NV] = '{64'd10, 64'd10, 64'd7, 64'd5, 64'd3, 64'd100};
    localparam logic [63:0] VPH [NV] = '{64'd2,  64'd2,  64'd0, 64'd4, 64'd1, 64'd37};
    localparam logic [63:0] VON [NV] = '{64'd7,  64'd3,  64'd7, 64'd1, 64'd0, 64'd60};
    localparam logic        VOV [NV] = '{1'b1,   1'b0,   1'b1,  1'b1,  1'b1,  1'b1};
    localparam logic [63:0] VT0 [NV] = '{64'd1000, 64'd1003, 64'd50, 64'd12345, 64'd77, 64'd5000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] time_cnt = '0;
    logic          cfg_enable = 1'b0;
    logic [TW-1:0] cfg_period = '0;
    logic [TW-1:0] cfg_phase = '0;
    logic [TW-1:0] cfg_on_time = '0;
    logic          cfg_on_valid = 1'b0;
    logic          pulse_out;
    logic          cfg_error;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    grid_pulse_gen #(.TW(TW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .time_cnt     (time_cnt),
        .cfg_enable   (cfg_enable),
        .cfg_period   (cfg_period),
        .cfg_phase    (cfg_phase),
        .cfg_on_time  (cfg_on_time),
        .cfg_on_valid (cfg_on_valid),
        .pulse_out    (pulse_out),
        .cfg_error    (cfg_error)
    );

    always #(CLK_PD / 2) clk = ~clk;

    task automatic chk(input logic got, input logic exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at t=%0d", tag, got, exp, time_cnt);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R4";
            1:       return "R5";
            2:       return "R9";
            4:       return "R3";
            default: return "R2";
        endcase
    endfunction

    // Enables a setup at counter t0 and compares every cycle with the model.
    task automatic run_case(input logic [63:0] p, input logic [63:0] ph, input logic [63:0] on,
                            input logic ov, input logic [63:0] t0, input bit poke,
                            input string tag);
        logic [63:0] first, r, g, eff, t;
        int ncyc;
        eff   = ov ? on : (p >> 1);
        first = t0 + 64'(TW);
        r     = (first - ph) % p;
        g     = (r == 0) ? first : first + (p - r);
        ncyc  = TW + 3 * int'(p) + 4;
        @(negedge clk);
        cfg_period = p; cfg_phase = ph; cfg_on_time = on; cfg_on_valid = ov;
        cfg_enable = 1'b1; time_cnt = t0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            t = time_cnt;
            if (i == 0) chk(cfg_error, 1'b0, tag);
            chk(pulse_out, (t >= g) && (((t - ph) % p) < eff), (t < g) ? "R8" : tag);
            if (poke && i == 3) begin
                cfg_period = 64'd4; cfg_phase = 64'd1; cfg_on_time = 64'd1; cfg_on_valid = 1'b0;
            end
            time_cnt = t + 64'd1;
        end
    endtask

    // Drops enable and checks that both outputs clear on the next edge.
    task automatic stop_case();
        cfg_enable = 1'b0;
        @(negedge clk);
        chk(pulse_out, 1'b0, "R11");
        chk(cfg_error, 1'b0, "R11");
        time_cnt = time_cnt + 64'd1;
    endtask

    // Applies a configuration and checks the error flag and a quiet output.
    task automatic err_case(input logic [63:0] p, input logic [63:0] ph, input logic [63:0] on,
                            input logic ov, input logic exp_err, input string tag);
        @(negedge clk);
        cfg_period = p; cfg_phase = ph; cfg_on_time = on; cfg_on_valid = ov;
        cfg_enable = 1'b1; time_cnt = 64'd400;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cfg_error, exp_err, tag);
            chk(pulse_out, 1'b0, tag);
            time_cnt = time_cnt + 64'd1;
        end
        @(negedge clk);
        stop_case();
    endtask

    initial begin
        // R1: outputs during and right after reset
        cfg_enable = 1'b1; cfg_period = 64'd10; cfg_phase = 64'd0; cfg_on_time = 64'd5;
        repeat (3) @(negedge clk);
        chk(pulse_out, 1'b0, "R1");
        chk(cfg_error, 1'b0, "R1");
        cfg_enable = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(pulse_out, 1'b0, "R1");
        chk(cfg_error, 1'b0, "R1");

        for (int i = 0; i < NV; i++) begin
            run_case(VP[i], VPH[i], VON[i], VOV[i], VT0[i], 1'b0, vec_tag(i));
            stop_case();
        end

        // R10: inputs changed while running are ignored
        run_case(64'd10, 64'd2, 64'd7, 1'b1, 64'd2000, 1'b1, "R10");
        stop_case();

        // R7, R6: rejections; an oversized on-time with the flag clear is fine
        err_case(64'd0,  64'd0,  64'd0,  1'b1, 1'b1, "R7");
        err_case(64'd10, 64'd10, 64'd3,  1'b1, 1'b1, "R7");
        err_case(64'd10, 64'd2,  64'd11, 1'b1, 1'b1, "R6");
        err_case(64'd10, 64'd2,  64'd11, 1'b0, 1'b0, "R6");

        // R11: disable mid-pulse, then restart from a fresh capture
        run_case(64'd10, 64'd2, 64'd7, 1'b1, 64'd3000, 1'b0, "R11");
        stop_case();
        run_case(64'd8, 64'd5, 64'd8, 1'b1, 64'd3100, 1'b0, "R9");
        stop_case();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule